// File: doc/BRIEF.md
# Secure-Aware Interrupt Urgency Arbiter

This block collects interrupt requests and decides which one to serve next. Each configurable request line has a 3-bit programmed priority and a security target bit. A global demotion bit moves Non-secure lines into the less urgent half of the 8-bit priority space. Three fixed system exceptions sit above every configurable line. A rising edge on a request line records it as pending. The block keeps a request pending until an acknowledge names its exception number.

On every clock the arbiter finds the most urgent pending request and registers it together with its effective priority. It also registers a preempt level. That level tells the core whether the winner may interrupt the handler that is running now. A numerically smaller priority is more urgent. Preemption needs a strictly smaller value than the active priority. The outputs are plain status pins with no back-pressure. The core reads them whenever it wants and returns an acknowledge when it takes an exception.

Top module: `irq_urgency_arbiter`

## Requirements
- R1: During and right after reset, nothing is pending and `win_valid` and `preempt` read 0. With no winner, `win_prio` reads 256.
- R2: A request line is marked pending only on a 0-to-1 transition of its input. A level held high after an acknowledge does not mark it pending again.
- R3: A cycle with `ack_valid` high clears the pending flag whose exception number equals `ack_num`. If a new rising edge arrives on that line in the same cycle, the line stays pending.
- R4: A Secure line (`irq_nonsec` bit 0) with programmed value v has effective priority 32·v.
- R5: A Non-secure line has effective priority 32·v while `ns_demote` is 0.
- R6: A Non-secure line has effective priority 128 + 16·v while `ns_demote` is 1.
- R7: Among pending requests, the one with the numerically lowest effective priority wins. Configurable line i carries exception number 16 + i.
- R8: When pending requests tie on effective priority, the lowest exception number wins.
- R9: System request bit 0 (exception 1) has priority −3, bit 1 (exception 2) has −2 and bit 2 (exception 3) has −1. Each outranks every configurable line.
- R10: `preempt` is 1 only when there is a winner and its effective priority is strictly lower than the active priority. An equal value never preempts.
- R11: While `active_valid` is 0, the active priority counts as 256, so any winner preempts.
- R12: A request whose priority equals the active priority stays pending and keeps `win_valid` high without raising `preempt`.
- R13: The outputs are registered. They reflect the pending state and the inputs at the previous clock edge, so a request edge first shows up two edges after it is driven.

Priority fields: `irq_prio` holds line i's value in bits [3i+2:3i]. `win_prio` and `active_prio` are signed two's-complement numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Request level for each configurable line |
| irq_prio | input | NUM_IRQ*PRIO_W | Programmed priority value for each line |
| irq_nonsec | input | NUM_IRQ | 1 = line targets the Non-secure state |
| ns_demote | input | 1 | Moves Non-secure priorities into 128..240 |
| sys_req | input | 3 | Fixed system requests (bit 0 most urgent) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | EXC_W | Exception number being acknowledged |
| active_valid | input | 1 | A handler is running |
| active_prio | input | 10 | Signed priority of the running handler |
| win_valid | output | 1 | A pending winner exists |
| win_num | output | EXC_W | Exception number of the winner |
| win_prio | output | 10 | Signed effective priority of the winner |
| preempt | output | 1 | The winner outranks the running handler |

## Verification
A corrupted pending flag shows at the ports within two clocks. A lost pending flag makes a request vanish from `win_num`. A stuck pending flag keeps serving a line after its acknowledge. A wrong priority map or tie rule shows up as a different `win_num` or `win_prio` in the cycle after the inputs change. A wrong comparison against the active priority flips `preempt` in that same cycle. The bench compares all four outputs against a behavioural model on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int EFF_W    = 8;
  localparam int URG_W    = 10;
  localparam int IRQ_BASE = 16;
  localparam int NSYS     = 3;

  typedef logic signed [URG_W-1:0] urg_t;

  localparam urg_t IDLE_URG = 10'sd256;
endpackage

// File: rtl/irqarb_pending.sv
module irqarb_pending
  import irqarb_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int FIRST_NUM = 16,
  parameter int EXC_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req,
  input  logic             ack_valid,
  input  logic [EXC_W-1:0] ack_num,
  output logic [LINES-1:0] pend
);
  logic [LINES-1:0] req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic rise, clr;
    assign rise = req[i] & ~req_q[i];
    assign clr  = ack_valid && (ack_num == EXC_W'(FIRST_NUM + i));
    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= rise | (pend[i] & ~clr);
    end
  end
endmodule

// File: rtl/irqarb_prio_map.sv
module irqarb_prio_map
  import irqarb_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic              nonsec,
  input  logic              demote,
  output urg_t              urg
);
  localparam int SEC_SH = EFF_W - PRIO_W;
  localparam int NS_SH  = SEC_SH - 1;

  logic [EFF_W-1:0] sec_val, ns_val, pick;

  assign sec_val = EFF_W'(prio) << SEC_SH;
  assign ns_val  = (EFF_W'(1) << (EFF_W - 1)) | (EFF_W'(prio) << NS_SH);
  assign pick    = (nonsec && demote) ? ns_val : sec_val;
  assign urg     = urg_t'({{(URG_W-EFF_W){1'b0}}, pick});
endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
  import irqarb_pkg::*;
#(
  parameter int NCAND = 11,
  parameter int EXC_W = 5
) (
  input  logic [NCAND-1:0] cand_valid,
  input  urg_t             cand_urg [NCAND],
  input  logic [EXC_W-1:0] cand_num [NCAND],
  output logic             any,
  output urg_t             best_urg,
  output logic [EXC_W-1:0] best_num
);
  always_comb begin
    any      = 1'b0;
    best_urg = IDLE_URG;
    best_num = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (cand_valid[i] && (!any || cand_urg[i] < best_urg)) begin
        any      = 1'b1;
        best_urg = cand_urg[i];
        best_num = cand_num[i];
      end
    end
  end
endmodule

// File: rtl/irq_urgency_arbiter.sv
module irq_urgency_arbiter
  import irqarb_pkg::*;
#(
  parameter int  NUM_IRQ = 8,
  parameter int  PRIO_W  = 3,
  localparam int EXC_W   = $clog2(IRQ_BASE + NUM_IRQ),
  localparam int NCAND   = NSYS + NUM_IRQ
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [NUM_IRQ-1:0]        irq_nonsec,
  input  logic                      ns_demote,
  input  logic [NSYS-1:0]           sys_req,
  input  logic                      ack_valid,
  input  logic [EXC_W-1:0]          ack_num,
  input  logic                      active_valid,
  input  logic signed [URG_W-1:0]   active_prio,
  output logic                      win_valid,
  output logic [EXC_W-1:0]          win_num,
  output logic signed [URG_W-1:0]   win_prio,
  output logic                      preempt
);
  logic [NSYS-1:0]    sys_pend;
  logic [NUM_IRQ-1:0] irq_pend;

  irqarb_pending #(.LINES(NSYS), .FIRST_NUM(1), .EXC_W(EXC_W)) u_sys_pend (
    .clk(clk), .rst_n(rst_n), .req(sys_req),
    .ack_valid(ack_valid), .ack_num(ack_num), .pend(sys_pend)
  );

  irqarb_pending #(.LINES(NUM_IRQ), .FIRST_NUM(IRQ_BASE), .EXC_W(EXC_W)) u_irq_pend (
    .clk(clk), .rst_n(rst_n), .req(irq_req),
    .ack_valid(ack_valid), .ack_num(ack_num), .pend(irq_pend)
  );

  urg_t             cand_urg [NCAND];
  logic [EXC_W-1:0] cand_num [NCAND];
  logic [NCAND-1:0] cand_valid;

  assign cand_valid = {irq_pend, sys_pend};

  for (genvar k = 0; k < NSYS; k++) begin : g_sys
    assign cand_urg[k] = urg_t'(k - NSYS);
    assign cand_num[k] = EXC_W'(k + 1);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    irqarb_prio_map #(.PRIO_W(PRIO_W)) u_map (
      .prio(irq_prio[i*PRIO_W +: PRIO_W]),
      .nonsec(irq_nonsec[i]),
      .demote(ns_demote),
      .urg(cand_urg[NSYS+i])
    );
    assign cand_num[NSYS+i] = EXC_W'(IRQ_BASE + i);
  end

  logic             any;
  urg_t             best_urg;
  logic [EXC_W-1:0] best_num;

  irqarb_select #(.NCAND(NCAND), .EXC_W(EXC_W)) u_sel (
    .cand_valid(cand_valid), .cand_urg(cand_urg), .cand_num(cand_num),
    .any(any), .best_urg(best_urg), .best_num(best_num)
  );

  urg_t active_urg;
  logic take;

  assign active_urg = active_valid ? active_prio : IDLE_URG;
  assign take       = any && (best_urg < active_urg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_num   <= '0;
      win_prio  <= IDLE_URG;
      preempt   <= 1'b0;
    end else begin
      win_valid <= any;
      win_num   <= best_num;
      win_prio  <= best_urg;
      preempt   <= take;
    end
  end
endmodule

// File: rtl/irqarb_checker.sv
module irqarb_checker
  import irqarb_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int EXC_W   = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    win_valid,
  input logic [EXC_W-1:0]        win_num,
  input logic signed [URG_W-1:0] win_prio,
  input logic                    preempt,
  input logic                    active_valid,
  input logic signed [URG_W-1:0] active_prio,
  input logic [NSYS-1:0]         pend_sys,
  input logic [NUM_IRQ-1:0]      pend_irq
);
  localparam urg_t MIN_U = -10'sd3;
  localparam urg_t MAX_U = 10'sd240;

  logic seen;
  urg_t act_now;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assign act_now = active_valid ? active_prio : IDLE_URG;

  p_preempt_has_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> win_valid);

  p_strict_preempt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && preempt) |-> (win_prio < $past(act_now)));

  p_equal_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && win_valid && $past(active_valid) && win_prio == $past(active_prio)) |-> !preempt);

  p_idle_takes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && win_valid && !$past(active_valid)) |-> preempt);

  p_reset_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(pend_sys[0])) |-> (win_valid && win_num == EXC_W'(1) && win_prio == MIN_U));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_prio >= MIN_U && win_prio <= MAX_U));

  p_empty_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(pend_sys == '0 && pend_irq == '0)) |-> !win_valid);
endmodule

bind irq_urgency_arbiter irqarb_checker #(.NUM_IRQ(NUM_IRQ), .EXC_W(EXC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_num(win_num),
  .win_prio(win_prio), .preempt(preempt), .active_valid(active_valid),
  .active_prio(active_prio), .pend_sys(sys_pend), .pend_irq(irq_pend)
);

// File: tb/irq_urgency_arbiter_test.sv
module irq_urgency_arbiter_test;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int EW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [N*PW-1:0] irq_prio = '0;
  logic [N-1:0]  irq_nonsec = '0;
  logic          ns_demote = 1'b0;
  logic [2:0]    sys_req = '0;
  logic          ack_valid = 1'b0;
  logic [EW-1:0] ack_num = '0;
  logic          active_valid = 1'b0;
  logic signed [9:0] active_prio = '0;
  logic          win_valid;
  logic [EW-1:0] win_num;
  logic signed [9:0] win_prio;
  logic          preempt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  irq_urgency_arbiter #(.NUM_IRQ(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_prio(irq_prio),
    .irq_nonsec(irq_nonsec), .ns_demote(ns_demote), .sys_req(sys_req),
    .ack_valid(ack_valid), .ack_num(ack_num), .active_valid(active_valid),
    .active_prio(active_prio), .win_valid(win_valid), .win_num(win_num),
    .win_prio(win_prio), .preempt(preempt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_sys[3];
  bit m_irq[N];
  bit p_sys[3];
  bit p_irq[N];
  int e_valid = 0, e_num = 0, e_prio = 256, e_pre = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_sys[k]) begin m_sys[k] = 0; p_sys[k] = 0; end
      foreach (m_irq[k]) begin m_irq[k] = 0; p_irq[k] = 0; end
      e_valid = 0; e_num = 0; e_prio = 256; e_pre = 0;
    end else begin
      int best, bnum, act;
      bit found;
      best = 1000; bnum = 0; found = 0;
      for (int k = 0; k < 3; k++)
        if (m_sys[k] && (k - 3) < best) begin best = k - 3; bnum = k + 1; found = 1; end
      for (int i = 0; i < N; i++) begin
        int v, u;
        v = int'(irq_prio[i*PW +: PW]);
        u = (irq_nonsec[i] && ns_demote) ? 128 + 16 * v : 32 * v;
        if (m_irq[i] && u < best) begin best = u; bnum = 16 + i; found = 1; end
      end
      act = active_valid ? int'(active_prio) : 256;
      e_valid = found;
      e_num = found ? bnum : 0;
      e_prio = found ? best : 256;
      e_pre = (found && best < act) ? 1 : 0;
      for (int k = 0; k < 3; k++) begin
        bit rise, clr;
        rise = sys_req[k] && !p_sys[k];
        clr = ack_valid && int'(ack_num) == k + 1;
        m_sys[k] = rise || (m_sys[k] && !clr);
        p_sys[k] = sys_req[k];
      end
      for (int i = 0; i < N; i++) begin
        bit rise, clr;
        rise = irq_req[i] && !p_irq[i];
        clr = ack_valid && int'(ack_num) == 16 + i;
        m_irq[i] = rise || (m_irq[i] && !clr);
        p_irq[i] = irq_req[i];
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk({phase, " R13 valid"}, int'(win_valid), e_valid);
      chk({phase, " R7 num"}, e_valid ? int'(win_num) : 0, e_num);
      if (e_valid) chk({phase, " R7 prio"}, int'(win_prio), e_prio);
      chk({phase, " R10 preempt"}, int'(preempt), e_pre);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(int num);
    ack_valid = 1'b1;
    ack_num = EW'(num);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic setp(int line, int v);
    irq_prio[line*PW +: PW] = PW'(v);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    step(3);
    chk("R1 reset valid", int'(win_valid), 0);
    chk("R1 reset preempt", int'(preempt), 0);
    chk("R1 reset prio", int'(win_prio), 256);
    rst_n = 1'b1;
    step(2);
    chk("R1 idle after reset", int'(win_valid), 0);

    phase = "R13";
    irq_req[0] = 1'b1;
    step(1);
    chk("R13 not yet visible", int'(win_valid), 0);
    step(1);
    chk("R13 visible after two edges", int'(win_num), 16);
    ack(16); irq_req[0] = 1'b0; step(2);

    phase = "R4";
    setp(2, 3); irq_req[2] = 1'b1;
    step(2);
    chk("R4 secure num", int'(win_num), 18);
    chk("R4 secure prio", int'(win_prio), 96);
    chk("R11 idle preempts", int'(preempt), 1);

    phase = "R12";
    active_valid = 1'b1; active_prio = 10'sd96;
    step(1);
    chk("R12 equal no preempt", int'(preempt), 0);
    chk("R12 still pending", int'(win_valid), 1);
    phase = "R10";
    active_prio = 10'sd128; step(1);
    chk("R10 lower value preempts", int'(preempt), 1);
    active_prio = 10'sd64; step(1);
    chk("R10 higher value holds", int'(preempt), 0);

    phase = "R3";
    ack(18); step(1);
    chk("R3 ack clears", int'(win_valid), 0);
    phase = "R2";
    step(2);
    chk("R2 held level no repend", int'(win_valid), 0);
    irq_req[2] = 1'b0;

    phase = "R6";
    active_valid = 1'b0;
    ns_demote = 1'b1; irq_nonsec[5] = 1'b1; setp(5, 3); setp(1, 6);
    irq_req[5] = 1'b1; irq_req[1] = 1'b1;
    step(2);
    chk("R6 demoted num", int'(win_num), 21);
    chk("R6 demoted prio", int'(win_prio), 176);
    phase = "R5";
    ns_demote = 1'b0; step(1);
    chk("R5 plain ns prio", int'(win_prio), 96);
    phase = "R8";
    setp(1, 3); step(1);
    chk("R8 tie lowest number", int'(win_num), 17);
    phase = "R7";
    setp(5, 1); step(1);
    chk("R7 lower value wins", int'(win_num), 21);
    chk("R7 lower value prio", int'(win_prio), 32);

    phase = "R9";
    sys_req = 3'b100; step(2);
    chk("R9 fault num", int'(win_num), 3);
    chk("R9 fault prio", int'(win_prio), -1);
    sys_req = 3'b110; step(2);
    chk("R9 nmi num", int'(win_num), 2);
    sys_req = 3'b111; step(2);
    chk("R9 reset num", int'(win_num), 1);
    chk("R9 reset prio", int'(win_prio), -3);
    sys_req = 3'b000;
    ack(1); ack(2); ack(3); ack(17); ack(21);
    irq_req = '0;
    step(2);

    phase = "R13 mixed";
    lf = 32'h1d2c_3b4a;
    for (int c = 0; c < 4000; c++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      irq_req = lf[7:0] & lf[15:8];
      if (lf[16]) irq_prio = {lf[23:0]} ^ {lf[7:0], lf[31:16]};
      irq_nonsec = lf[31:24];
      ns_demote = lf[20];
      active_valid = lf[21];
      active_prio = 10'($signed({1'b0, lf[26:24], 5'b0})) - (lf[17] ? 10'sd2 : 10'sd0);
      sys_req = lf[30:28] & {3{lf[19] & lf[18] & lf[9]}};
      ack_valid = lf[27];
      ack_num = win_valid ? win_num : EW'(16 + int'(lf[2:0]));
      @(negedge clk);
    end
    ack_valid = 1'b0;
    step(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule